// File: doc/BRIEF.md
# Timer Capture/Compare Event Channel

This block is one channel of a general-purpose timer. A free-running up-counter advances on every system clock. Software loads a compare value; when the counter lands exactly on it, a sticky compare event is recorded. An external input pin is synchronised to the clock and watched for edges. The active edge kind is programmable. A qualifying edge copies the running count into a capture register and records a sticky capture event.

Each recorded event can be turned into a service request. A single routing bit selects whether every enabled event drives the interrupt line or the DMA request line. Both request outputs are plain levels. They stay high while an enabled event is pending, and software clears an event by writing a one to its bit. A small word-wide register port reads and writes the control word, the compare value, the captured value, the event bits and the running count.

Top module: `evt_timer_chan`

## Requirements
- R1: While reset is held: count reads 0, compare reads 0xFFFF_FFFF, capture reads 0, event and control read 0, and irq_o and dma_req_o are low.
- R2: The count (address 4, read-only) rises by exactly one on every clock edge after reset is released, and wraps to zero after its maximum.
- R3: Event bit 1 (address 3) becomes 1 on the edge that follows a cycle in which the count equals the compare value (address 1) exactly, and never sets otherwise.
- R4: Writing address 3 clears each event bit written as 1. Each bit written as 0 keeps its value.
- R5: When a clear and a new event hit the same event bit in the same cycle, the bit ends up 1.
- R6: Control bits [2:1] select the capture edge: 0 none, 1 rising only, 2 falling only, 3 both. Suppose the pin changes before clock edge k. If that change qualifies, then after edge k+2 the capture register (address 2) holds the count that was readable just before edge k, plus 2.
- R7: A capture event sets event bit 0. With capture disabled, pin activity sets no event and leaves the capture register unchanged. Bus writes to addresses 2 and 4 have no effect.
- R8: Control bit 0 enables requests from the compare event. With it at 0 a pending compare event drives no output. With it at 1, the event drives irq_o when control bit 3 is 0 and dma_req_o when control bit 3 is 1.
- R9: When capture is enabled (bits [2:1] not 0), a pending capture event drives irq_o if control bit 3 is 0 and dma_req_o if it is 1.
- R10: Event bits 7..2 and control bits above 3 always read as 0, whatever value was written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the count clock |
| rst_n | input | 1 | Active-low reset |
| cap_pin_i | input | 1 | Asynchronous capture input |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Register address (0 control, 1 compare, 2 capture, 3 event, 4 count) |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for bus_addr_i, combinational |
| irq_o | output | 1 | Interrupt request level |
| dma_req_o | output | 1 | DMA request level |

## Verification
The bench aims a compare match at the exact cycle of a write-one-clear. A design where the clear wins would lose that event. It also checks the compare flag one cycle before and one cycle after the match, which exposes an off-by-one compare or a compare that uses magnitude rather than equality. Captures are checked for each edge setting in both pin directions, and the captured count is checked against a hand-derived two-flop latency. This catches a missing synchroniser stage, swapped rising and falling codes, or a latch while capture is disabled. Routing is checked for each combination of enable and DMA bit, and a constrained-random phase compares every readable register and both request lines against a model built from the requirements.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

   typedef enum logic [1:0] {
      EDGE_OFF  = 2'd0,
      EDGE_RISE = 2'd1,
      EDGE_FALL = 2'd2,
      EDGE_BOTH = 2'd3
   } edge_sel_e;

   typedef struct packed {
      logic      dma_route;
      edge_sel_e edge_sel;
      logic      cmp_req_en;
   } chan_ctrl_t;

   localparam int CTRL_BITS = 4;
   localparam int EVT_BITS  = 8;

   localparam int unsigned ADR_CTRL = 0;
   localparam int unsigned ADR_CMP  = 1;
   localparam int unsigned ADR_CAP  = 2;
   localparam int unsigned ADR_EVT  = 3;
   localparam int unsigned ADR_CNT  = 4;

   localparam int EVT_CAP_BIT = 0;
   localparam int EVT_CMP_BIT = 1;

endpackage

// File: rtl/evt_free_cnt.sv
module evt_free_cnt #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [CNT_W-1:0] cnt_o
);
   localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_q + STEP;
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/evt_edge_sync.sv
module evt_edge_sync
   import evt_timer_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      pin_i,
   input  edge_sel_e edge_sel_i,
   output logic      hit_o
);
   localparam int LAST = SYNC_STAGES - 1;

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("evt_edge_sync: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   rise, fall;

   for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[0] <= 1'b0;
            else        sync_q[0] <= pin_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[s] <= 1'b0;
            else        sync_q[s] <= sync_q[s-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sync_q[LAST];
   end

   assign rise = sync_q[LAST] & ~prev_q;
   assign fall = ~sync_q[LAST] & prev_q;

   always_comb begin
      unique case (edge_sel_i)
         EDGE_RISE: hit_o = rise;
         EDGE_FALL: hit_o = fall;
         EDGE_BOTH: hit_o = rise | fall;
         default:   hit_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/evt_flag_route.sv
module evt_flag_route
   import evt_timer_pkg::*;
#(
   parameter int N_EVT = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_EVT-1:0] set_i,
   input  logic [N_EVT-1:0] clr_i,
   input  logic [N_EVT-1:0] req_en_i,
   input  logic             dma_route_i,
   output logic [N_EVT-1:0] flags_o,
   output logic             irq_o,
   output logic             dma_o
);
   if (N_EVT < 1) begin : g_bad_n
      $error("evt_flag_route: N_EVT must be at least 1");
   end

   logic [N_EVT-1:0] flag_q;
   logic [N_EVT-1:0] pend;

   for (genvar e = 0; e < N_EVT; e++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         flag_q[e] <= 1'b0;
         else if (set_i[e])  flag_q[e] <= 1'b1;
         else if (clr_i[e])  flag_q[e] <= 1'b0;
      end
      assign pend[e] = flag_q[e] & req_en_i[e];
   end

   assign flags_o = flag_q;
   assign irq_o   = (|pend) & ~dma_route_i;
   assign dma_o   = (|pend) &  dma_route_i;
endmodule

// File: rtl/evt_timer_chan.sv
module evt_timer_chan
   import evt_timer_pkg::*;
#(
   parameter int CNT_W       = 32,
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_pin_i,
   input  logic              bus_wr_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic              irq_o,
   output logic              dma_req_o
);
   localparam int N_EVT = 2;
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADR_CTRL);
   localparam logic [ADDR_W-1:0] A_CMP  = ADDR_W'(ADR_CMP);
   localparam logic [ADDR_W-1:0] A_CAP  = ADDR_W'(ADR_CAP);
   localparam logic [ADDR_W-1:0] A_EVT  = ADDR_W'(ADR_EVT);
   localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(ADR_CNT);

   if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("evt_timer_chan: CNT_W must lie in 2..DATA_W");
   end
   if (DATA_W < EVT_BITS) begin : g_bad_data
      $error("evt_timer_chan: DATA_W must hold the event register");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("evt_timer_chan: ADDR_W must reach five registers");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] ref_q;
   logic [CNT_W-1:0] cap_q;
   chan_ctrl_t       ctrl_q;
   logic             cap_hit;
   logic             ref_hit;
   logic [N_EVT-1:0] flags;
   logic [N_EVT-1:0] evt_set, evt_clr, evt_en;
   logic             wr_ctrl, wr_cmp, wr_evt;
   wire              unused_wdata = ^bus_wdata_i;

   assign wr_ctrl = bus_wr_i && (bus_addr_i == A_CTRL);
   assign wr_cmp  = bus_wr_i && (bus_addr_i == A_CMP);
   assign wr_evt  = bus_wr_i && (bus_addr_i == A_EVT);

   evt_free_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .cnt_o (cnt_q)
   );

   evt_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin_i      (cap_pin_i),
      .edge_sel_i (ctrl_q.edge_sel),
      .hit_o      (cap_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (wr_ctrl) ctrl_q <= chan_ctrl_t'(bus_wdata_i[CTRL_BITS-1:0]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ref_q <= '1;
      else if (wr_cmp) ref_q <= bus_wdata_i[CNT_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cap_q <= '0;
      else if (cap_hit) cap_q <= cnt_q;
   end

   assign ref_hit = (cnt_q == ref_q);

   assign evt_set[EVT_CAP_BIT] = cap_hit;
   assign evt_set[EVT_CMP_BIT] = ref_hit;
   assign evt_clr[EVT_CAP_BIT] = wr_evt & bus_wdata_i[EVT_CAP_BIT];
   assign evt_clr[EVT_CMP_BIT] = wr_evt & bus_wdata_i[EVT_CMP_BIT];
   assign evt_en[EVT_CAP_BIT]  = (ctrl_q.edge_sel != EDGE_OFF);
   assign evt_en[EVT_CMP_BIT]  = ctrl_q.cmp_req_en;

   evt_flag_route #(.N_EVT(N_EVT)) u_flags (
      .clk         (clk),
      .rst_n       (rst_n),
      .set_i       (evt_set),
      .clr_i       (evt_clr),
      .req_en_i    (evt_en),
      .dma_route_i (ctrl_q.dma_route),
      .flags_o     (flags),
      .irq_o       (irq_o),
      .dma_o       (dma_req_o)
   );

   always_comb begin
      bus_rdata_o = '0;
      unique case (bus_addr_i)
         A_CTRL: bus_rdata_o[CTRL_BITS-1:0] = ctrl_q;
         A_CMP:  bus_rdata_o[CNT_W-1:0]     = ref_q;
         A_CAP:  bus_rdata_o[CNT_W-1:0]     = cap_q;
         A_EVT:  bus_rdata_o[N_EVT-1:0]     = flags;
         A_CNT:  bus_rdata_o[CNT_W-1:0]     = cnt_q;
         default: bus_rdata_o = '0;
      endcase
   end
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
   parameter int CNT_W  = 32,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr_i,
   input logic [ADDR_W-1:0] bus_addr_i,
   input logic [DATA_W-1:0] bus_wdata_i,
   input logic [DATA_W-1:0] bus_rdata_o,
   input logic              irq_o,
   input logic              dma_req_o,
   input logic [CNT_W-1:0]  cnt,
   input logic [CNT_W-1:0]  ref_val,
   input logic [CNT_W-1:0]  cap_val,
   input logic [1:0]        flags,
   input logic [3:0]        ctrl,
   input logic              cap_hit
);
   localparam logic [ADDR_W-1:0] A_EVT = ADDR_W'(3);
   logic wr_evt;
   assign wr_evt = bus_wr_i && (bus_addr_i == A_EVT);

   assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (cnt - $past(cnt)) == CNT_W'(1));

   assert_cmp_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == ref_val) |=> flags[1]);

   assert_cmp_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[1]) |-> $past(cnt == ref_val));

   assert_w1c_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_evt && bus_wdata_i[1] && (cnt != ref_val)) |=> !flags[1]);

   assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_evt && bus_wdata_i[0] && cap_hit) |=> flags[0]);

   assert_cap_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cap_hit |=> (cap_val == $past(cnt)));

   assert_cap_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_hit |=> $stable(cap_val));

   assert_dma_route_R8: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req_o |-> (ctrl[3] && (flags != 2'b00)));

   assert_irq_route_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (!ctrl[3] && (flags != 2'b00)));

   assert_rsvd_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr_i == A_EVT) |-> (bus_rdata_o[7:2] == 6'd0));
endmodule

bind evt_timer_chan evt_timer_chk #(
   .CNT_W  (CNT_W),
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_wr_i    (bus_wr_i),
   .bus_addr_i  (bus_addr_i),
   .bus_wdata_i (bus_wdata_i),
   .bus_rdata_o (bus_rdata_o),
   .irq_o       (irq_o),
   .dma_req_o   (dma_req_o),
   .cnt         (cnt_q),
   .ref_val     (ref_q),
   .cap_val     (cap_q),
   .flags       (flags),
   .ctrl        (ctrl_q),
   .cap_hit     (cap_hit)
);

// File: tb/tb_evt_timer_chan.sv
`timescale 1ns/1ps
module tb_evt_timer_chan;
   localparam real TCLK = 8.0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pin = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = 3'd0;
   logic [31:0] bus_wdata = 32'd0;
   logic [31:0] bus_rdata;
   logic        irq, dma;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(TCLK/2) clk = ~clk;

   evt_timer_chan dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .cap_pin_i   (pin),
      .bus_wr_i    (bus_wr),
      .bus_addr_i  (bus_addr),
      .bus_wdata_i (bus_wdata),
      .bus_rdata_o (bus_rdata),
      .irq_o       (irq),
      .dma_req_o   (dma)
   );

   // reference model built from the requirements
   logic [31:0] m_cnt, m_ref, m_cap;
   logic [3:0]  m_ctrl;
   logic [1:0]  m_flags;
   logic        m_s1, m_s2, m_prev;

   function automatic logic m_qualify();
      logic r, f;
      r = m_s2 & ~m_prev;
      f = ~m_s2 & m_prev;
      case (m_ctrl[2:1])
         2'd1: return r;
         2'd2: return f;
         2'd3: return r | f;
         default: return 1'b0;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt <= 0; m_ref <= '1; m_cap <= 0; m_ctrl <= 0; m_flags <= 0;
         m_s1 <= 0; m_s2 <= 0; m_prev <= 0;
      end else begin
         logic q, hit;
         logic [1:0] clr;
         q   = m_qualify();
         hit = (m_cnt == m_ref);
         clr = (bus_wr && bus_addr == 3'd3) ? bus_wdata[1:0] : 2'b00;
         m_flags <= (m_flags & ~clr) | {hit, q};
         if (q) m_cap <= m_cnt;
         if (bus_wr && bus_addr == 3'd1) m_ref <= bus_wdata;
         if (bus_wr && bus_addr == 3'd0) m_ctrl <= bus_wdata[3:0];
         m_cnt <= m_cnt + 1;
         m_s1 <= pin; m_s2 <= m_s1; m_prev <= m_s2;
      end
   end

   function automatic logic [31:0] m_read(input logic [2:0] a);
      case (a)
         3'd0: return {28'd0, m_ctrl};
         3'd1: return m_ref;
         3'd2: return m_cap;
         3'd3: return {30'd0, m_flags};
         3'd4: return m_cnt;
         default: return 32'd0;
      endcase
   endfunction

   function automatic logic [1:0] m_req();
      logic p;
      p = (m_flags[1] & m_ctrl[0]) | (m_flags[0] & (m_ctrl[2:1] != 2'd0));
      return {p & m_ctrl[3], p & ~m_ctrl[3]};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] v);
      bus_addr = a;
      #1;
      v = bus_rdata;
   endtask

   task automatic wr_now(input logic [2:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R1 watchdog actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      logic [31:0] v, c, capv;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      // R1 reset state
      rd(3'd4, v); chk("R1 count", v, 32'd0);
      rd(3'd1, v); chk("R1 compare", v, 32'hFFFF_FFFF);
      rd(3'd2, v); chk("R1 capture", v, 32'd0);
      rd(3'd3, v); chk("R1 event", v, 32'd0);
      rd(3'd0, v); chk("R1 control", v, 32'd0);
      chk("R1 requests", {30'd0, dma, irq}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 step
      rd(3'd4, c);
      repeat (5) @(negedge clk);
      rd(3'd4, v); chk("R2 count step", v, c + 5);

      // R3 exact match timing
      wr_now(3'd3, 32'd3);
      rd(3'd4, c);
      wr_now(3'd1, c + 5);
      repeat (4) @(negedge clk);
      rd(3'd3, v); chk("R3 before match", v & 32'd2, 32'd0);
      @(negedge clk);
      rd(3'd3, v); chk("R3 after match", v & 32'd2, 32'd2);

      // R4 write-one-clear
      wr_now(3'd1, 32'h8000_0000);
      wr_now(3'd3, 32'd1);
      rd(3'd3, v); chk("R4 zero keeps", v & 32'd2, 32'd2);
      wr_now(3'd3, 32'd2);
      rd(3'd3, v); chk("R4 one clears", v & 32'd2, 32'd0);

      // R5 set beats clear
      rd(3'd4, c);
      wr_now(3'd1, c + 3);
      repeat (2) @(negedge clk);
      wr_now(3'd3, 32'd2);
      rd(3'd3, v); chk("R5 set wins", v & 32'd2, 32'd2);

      // R8 compare routing
      chk("R8 disabled", {30'd0, dma, irq}, 32'd0);
      wr_now(3'd0, 32'd1);
      chk("R8 irq route", {30'd0, dma, irq}, 32'd1);
      wr_now(3'd0, 32'd9);
      chk("R8 dma route", {30'd0, dma, irq}, 32'd2);
      wr_now(3'd3, 32'd2);
      chk("R8 cleared", {30'd0, dma, irq}, 32'd0);
      wr_now(3'd0, 32'd0);

      // R6 rising only
      wr_now(3'd0, 32'd2);
      wr_now(3'd3, 32'd3);
      rd(3'd4, c); pin = 1'b1;
      repeat (3) @(negedge clk);
      rd(3'd2, v); chk("R6 rise capture", v, c + 2);
      rd(3'd3, v); chk("R7 capture flag", v & 32'd1, 32'd1);
      chk("R9 capture irq", {30'd0, dma, irq}, 32'd1);
      wr_now(3'd3, 32'd1);
      rd(3'd2, capv); pin = 1'b0;
      repeat (4) @(negedge clk);
      rd(3'd2, v); chk("R6 rise ignores fall", v, capv);
      rd(3'd3, v); chk("R6 rise no flag", v & 32'd1, 32'd0);

      // R6 falling only, DMA route
      wr_now(3'd0, 32'd12);
      pin = 1'b1;
      repeat (4) @(negedge clk);
      rd(3'd2, v); chk("R6 fall ignores rise", v, capv);
      rd(3'd4, c); pin = 1'b0;
      repeat (3) @(negedge clk);
      rd(3'd2, v); chk("R6 fall capture", v, c + 2);
      chk("R9 capture dma", {30'd0, dma, irq}, 32'd2);
      wr_now(3'd3, 32'd1);

      // R6 both edges
      wr_now(3'd0, 32'd6);
      rd(3'd4, c); pin = 1'b1;
      repeat (3) @(negedge clk);
      rd(3'd2, v); chk("R6 both rise", v, c + 2);
      wr_now(3'd3, 32'd1);
      rd(3'd4, c); pin = 1'b0;
      repeat (3) @(negedge clk);
      rd(3'd2, v); chk("R6 both fall", v, c + 2);
      wr_now(3'd3, 32'd1);

      // R7 capture disabled
      wr_now(3'd0, 32'd8);
      rd(3'd2, capv); pin = 1'b1;
      repeat (4) @(negedge clk);
      pin = 1'b0;
      repeat (4) @(negedge clk);
      rd(3'd2, v); chk("R7 disabled capture", v, capv);
      rd(3'd3, v); chk("R7 disabled flag", v & 32'd1, 32'd0);
      chk("R7 disabled requests", {30'd0, dma, irq}, 32'd0);
      wr_now(3'd2, 32'h1234_5678);
      rd(3'd2, v); chk("R7 capture read-only", v, capv);

      // R10 reserved bits
      wr_now(3'd0, 32'hFFFF_FFF0);
      rd(3'd0, v); chk("R10 control high bits", v, 32'd0);
      wr_now(3'd0, 32'hFFFF_FFFF);
      rd(3'd0, v); chk("R10 control width", v, 32'hF);
      wr_now(3'd0, 32'd0);
      wr_now(3'd3, 32'hFFFF_FFFC);
      rd(3'd3, v); chk("R10 event reserved", v, 32'd0);

      // constrained random against the model
      for (int i = 0; i < 3000; i++) begin
         logic [2:0] a;
         string tag;
         @(negedge clk);
         if ($urandom_range(2) == 0) pin = ~pin;
         a = 3'($urandom_range(4));
         bus_wr = ($urandom_range(7) == 0);
         bus_addr = a;
         case (a)
            3'd1:    bus_wdata = m_cnt + 32'($urandom_range(12));
            3'd0:    bus_wdata = $urandom;
            default: bus_wdata = $urandom;
         endcase
         #1;
         case (a)
            3'd0: tag = "R10 random control";
            3'd1: tag = "R3 random compare";
            3'd2: tag = "R6 random capture";
            3'd3: tag = "R4 random event";
            default: tag = "R2 random count";
         endcase
         chk(tag, bus_rdata, m_read(a));
         if ((i % 4) == 0) chk("R9 random requests", {30'd0, dma, irq}, {30'd0, m_req()});
      end
      @(negedge clk);
      bus_wr = 1'b0;
      @(negedge clk);
      finish_run();
   end
endmodule